// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is a single output cell for a sum-of-products programmable logic array. It takes one sum term from the OR plane and produces three things: the value driven toward the pin, an output-enable for that pin, and a feedback bit that returns to the AND plane. A four-bit static code sets how the cell behaves. It chooses a flip-flop or a straight combinational path, true or inverted output, one of two clocks for the flip-flop, and whether feedback comes from the register or from the pin.

The flip-flop has four controls. A power-on clear and a global asynchronous clear both force it to 0 at once. A global synchronous preset forces it to 1 on the next edge of the chosen clock. A test preload writes an arbitrary bit on that edge. The configuration code is meant to change only while the power-on clear is held, so that the clock selection never switches during operation. Tristating the pin is left to the pad: the cell reports this through its enable output.

Top module: `pal_macrocell`

## Requirements
- R1: With mode bit 0 = 1 the pin value comes from the register. With bit 0 = 0 the pin value follows `sumIn` with no clock edge needed.
- R2: Mode bit 1 = 1 inverts the pin value on both paths. Bit 1 = 0 passes the value through unchanged.
- R3: Mode bit 2 = 0 clocks the register from `clkA`, and bit 2 = 1 clocks it from `clkB`. Edges on the clock that is not selected leave the register unchanged.
- R4: On a rising edge of the selected clock, with no preload, preset or clear active, the register takes `sumIn` (the true sum, before any inversion).
- R5: `arstIn` high clears the register at once, without a clock edge. It overrides both preset and preload for as long as it is held.
- R6: `presetIn` high with `preloadEn` low sets the register to 1 on the next rising edge of the selected clock.
- R7: `preloadEn` high writes `preloadVal` into the register on the next rising edge of the selected clock. Preload takes priority over preset and over the sum term.
- R8: `porIn` high clears the register asynchronously. While it is held, the pin value equals the mode's polarity applied to a 0 register or to `sumIn`.
- R9: `fbOut` equals `padIn` when `oeIn` is low or when mode bit 3 = 1. Otherwise `fbOut` equals the true register value.
- R10: `padOe` follows `oeIn`. When it is low, the pin is meant to be in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | First register clock |
| clkB | input | 1 | Second register clock |
| porIn | input | 1 | Power-on clear, active high, asynchronous |
| arstIn | input | 1 | Global asynchronous clear, active high |
| presetIn | input | 1 | Global synchronous preset, active high |
| preloadEn | input | 1 | Test preload strobe, active high |
| preloadVal | input | 1 | Value written by the preload |
| cfgBits | input | 4 | Mode code: bit0 registered, bit1 invert, bit2 clock B, bit3 pin feedback |
| sumIn | input | 1 | Sum term from the OR array |
| oeIn | input | 1 | Output enable term |
| padIn | input | 1 | Level seen at the pin |
| padOut | output | 1 | Value to drive on the pin |
| padOe | output | 1 | Pin drive enable |
| fbOut | output | 1 | Feedback toward the AND array |

## Verification
The cell has no tunable parameters. The mode code width and bit positions are package constants, so the bench builds the one default configuration and runs the cell through all sixteen mode codes, each started from a fresh power-on clear. The clock generators can be gated, so one clock can be stopped while the other keeps running. This makes it possible to show that the unselected clock has no effect, in both directions. Directed steps cover a clear raised between edges, a clear colliding with a preset, and a preload colliding with a preset. The random phase mixes rare preset and preload strobes with random enables and pin levels.

// File: rtl/pal_macrocell_pkg.sv
package pal_macrocell_pkg;

  // Width of the static mode code and the position of each field in it.
  localparam int CFG_W   = 4;
  localparam int BIT_REG = 0;
  localparam int BIT_INV = 1;
  localparam int BIT_CLK = 2;
  localparam int BIT_FB  = 3;

  // Decoded static mode of the cell.
  typedef struct packed {
    logic regPath;
    logic invert;
    logic useClkB;
    logic fbFromPin;
  } cellMode_t;

  // Strobes from control to the register datapath.
  typedef struct packed {
    logic clear;
    logic load;
    logic loadVal;
    logic preset;
  } regStrobe_t;

endpackage

// File: rtl/pal_macrocell_ctrl.sv
module pal_macrocell_ctrl
  import pal_macrocell_pkg::*;
(
  input  logic [CFG_W-1:0] cfgBits,
  input  logic             porIn,
  input  logic             arstIn,
  input  logic             presetIn,
  input  logic             preloadEn,
  input  logic             preloadVal,
  output cellMode_t        mode,
  output regStrobe_t       strobes
);

  always_comb begin
    mode.regPath   = cfgBits[BIT_REG];
    mode.invert    = cfgBits[BIT_INV];
    mode.useClkB   = cfgBits[BIT_CLK];
    mode.fbFromPin = cfgBits[BIT_FB];
  end

  // Either clear source acts at once; preload outranks preset.
  always_comb begin
    strobes.clear   = porIn | arstIn;
    strobes.load    = preloadEn;
    strobes.loadVal = preloadVal;
    strobes.preset  = presetIn & ~preloadEn;
  end

endmodule

// File: rtl/pal_macrocell_datapath.sv
module pal_macrocell_datapath
  import pal_macrocell_pkg::*;
(
  input  logic       clkA,
  input  logic       clkB,
  input  cellMode_t  mode,
  input  regStrobe_t strobes,
  input  logic       sumIn,
  input  logic       oeIn,
  input  logic       padIn,
  output logic       padOut,
  output logic       padOe,
  output logic       fbOut
);

  logic regClk;
  logic clrAsync;
  logic nextQ;
  logic qReg;
  logic coreVal;

  // Static clock choice; the mode only changes under power-on clear.
  assign regClk   = mode.useClkB ? clkB : clkA;
  assign clrAsync = strobes.clear;

  always_comb begin
    if (strobes.load)        nextQ = strobes.loadVal;
    else if (strobes.preset) nextQ = 1'b1;
    else                     nextQ = sumIn;
  end

  always_ff @(posedge regClk or posedge clrAsync) begin
    if (clrAsync) qReg <= 1'b0;
    else          qReg <= nextQ;
  end

  assign coreVal = mode.regPath ? qReg : sumIn;
  assign padOut  = coreVal ^ mode.invert;
  assign padOe   = oeIn;
  // A disabled pin always feeds its own level back.
  assign fbOut   = (mode.fbFromPin | ~oeIn) ? padIn : qReg;

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_macrocell_pkg::*;
(
  input  logic             clkA,
  input  logic             clkB,
  input  logic             porIn,
  input  logic             arstIn,
  input  logic             presetIn,
  input  logic             preloadEn,
  input  logic             preloadVal,
  input  logic [CFG_W-1:0] cfgBits,
  input  logic             sumIn,
  input  logic             oeIn,
  input  logic             padIn,
  output logic             padOut,
  output logic             padOe,
  output logic             fbOut
);

  cellMode_t  mode;
  regStrobe_t strobes;

  pal_macrocell_ctrl u_ctrl (
    .cfgBits    (cfgBits),
    .porIn      (porIn),
    .arstIn     (arstIn),
    .presetIn   (presetIn),
    .preloadEn  (preloadEn),
    .preloadVal (preloadVal),
    .mode       (mode),
    .strobes    (strobes)
  );

  pal_macrocell_datapath u_dp (
    .clkA    (clkA),
    .clkB    (clkB),
    .mode    (mode),
    .strobes (strobes),
    .sumIn   (sumIn),
    .oeIn    (oeIn),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .fbOut   (fbOut)
  );

endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk
  import pal_macrocell_pkg::*;
(
  input logic             clkA,
  input logic             porIn,
  input logic             arstIn,
  input logic             presetIn,
  input logic             preloadEn,
  input logic             preloadVal,
  input logic [CFG_W-1:0] cfgBits,
  input logic             sumIn,
  input logic             oeIn,
  input logic             padIn,
  input logic             padOut,
  input logic             fbOut
);

  p_comb_path_r1: assert property (@(posedge clkA) disable iff (porIn)
    (!cfgBits[BIT_REG]) |-> (padOut == (sumIn ^ cfgBits[BIT_INV])));

  p_async_clear_r5: assert property (@(posedge clkA) disable iff (porIn)
    (arstIn && cfgBits[BIT_REG]) |-> (padOut == cfgBits[BIT_INV]));

  p_preset_r6: assert property (@(posedge clkA) disable iff (porIn || arstIn)
    (!cfgBits[BIT_CLK] && cfgBits[BIT_REG] &&
     $past(presetIn && !preloadEn && !porIn && !arstIn))
    |-> (padOut == !cfgBits[BIT_INV]));

  p_preload_r7: assert property (@(posedge clkA) disable iff (porIn || arstIn)
    (!cfgBits[BIT_CLK] && cfgBits[BIT_REG] &&
     $past(preloadEn && !porIn && !arstIn))
    |-> (padOut == ($past(preloadVal) ^ cfgBits[BIT_INV])));

  p_pin_feedback_r9: assert property (@(posedge clkA) disable iff (porIn)
    (!oeIn || cfgBits[BIT_FB]) |-> (fbOut == padIn));

endmodule

bind pal_macrocell pal_macrocell_chk u_chk (
  .clkA       (clkA),
  .porIn      (porIn),
  .arstIn     (arstIn),
  .presetIn   (presetIn),
  .preloadEn  (preloadEn),
  .preloadVal (preloadVal),
  .cfgBits    (cfgBits),
  .sumIn      (sumIn),
  .oeIn       (oeIn),
  .padIn      (padIn),
  .padOut     (padOut),
  .fbOut      (fbOut)
);

// File: tb/sim_pal_macrocell.sv
module sim_pal_macrocell;

  logic clkA = 1'b0, clkB = 1'b0, enA = 1'b1, enB = 1'b1;
  always #10 if (enA) clkA = ~clkA;   // 50 MHz
  always #7  if (enB) clkB = ~clkB;

  logic [3:0] cfgBits = 4'b0000;
  logic porIn = 1'b1, arstIn = 1'b0, presetIn = 1'b0;
  logic preloadEn = 1'b0, preloadVal = 1'b0;
  logic sumIn = 1'b0, oeIn = 1'b1, padIn = 1'b0;
  logic padOut, padOe, fbOut;

  int nChecks = 0, nFail = 0;
  logic refQ = 1'b0;

  pal_macrocell u0 (
    .clkA(clkA), .clkB(clkB), .porIn(porIn), .arstIn(arstIn),
    .presetIn(presetIn), .preloadEn(preloadEn), .preloadVal(preloadVal),
    .cfgBits(cfgBits), .sumIn(sumIn), .oeIn(oeIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );

  function automatic logic expPad(input logic [3:0] c, input logic q, input logic s);
    return (c[0] ? q : s) ^ c[1];
  endfunction

  function automatic logic expFb(input logic [3:0] c, input logic q, input logic oe, input logic pd);
    return (c[3] || !oe) ? pd : q;
  endfunction

  function automatic logic calcNext(input logic pl, input logic plv, input logic pr, input logic s);
    if (pl) return plv;
    if (pr) return 1'b1;
    return s;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b (cfg %b)", tag, act, exp, cfgBits);
    end
  endtask

  task automatic selNeg();
    if (cfgBits[2]) @(negedge clkB); else @(negedge clkA);
  endtask

  task automatic selPos();
    if (cfgBits[2]) @(posedge clkB); else @(posedge clkA);
  endtask

  task automatic startCfg(input logic [3:0] c);
    porIn = 1'b1; arstIn = 1'b0; presetIn = 1'b0; preloadEn = 1'b0;
    preloadVal = 1'b0; sumIn = 1'b0; oeIn = 1'b1; padIn = 1'b0; cfgBits = c;
    #30;
    refQ = 1'b0;
    chk("R8 output under power-on clear", padOut, expPad(c, 1'b0, 1'b0));
    chk("R8 feedback under power-on clear", fbOut, expFb(c, 1'b0, 1'b1, 1'b0));
    selNeg();
    porIn = 1'b0;
  endtask

  task automatic applyVec(input logic s, input logic pr, input logic pl,
                          input logic plv, input logic oe, input logic pd);
    selNeg();
    sumIn = s; presetIn = pr; preloadEn = pl; preloadVal = plv; oeIn = oe; padIn = pd;
    #1;
    chk("R1/R2 pin before edge", padOut, expPad(cfgBits, refQ, s));
    chk("R9 feedback before edge", fbOut, expFb(cfgBits, refQ, oe, pd));
    chk("R10 enable", padOe, oe);
    selPos();
    refQ = calcNext(pl, plv, pr, s);
    #2;
    chk("R4/R6/R7 pin after edge", padOut, expPad(cfgBits, refQ, s));
    chk("R9 feedback after edge", fbOut, expFb(cfgBits, refQ, oe, pd));
  endtask

  initial begin
    void'($urandom(32'd1234));

    // Registered, true polarity, clock A
    startCfg(4'b0001);
    applyVec(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);   // R4 q=1
    applyVec(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);   // R6 preset
    applyVec(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);   // R7 preload beats preset
    applyVec(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);   // R7 preload 1

    // R5: clear between edges, then against a preset
    selNeg();
    sumIn = 1'b1; presetIn = 1'b1; preloadEn = 1'b0;
    #3 arstIn = 1'b1;
    #1 refQ = 1'b0;
    chk("R5 clear without edge", padOut, expPad(cfgBits, 1'b0, 1'b1));
    chk("R5 clear seen on feedback", fbOut, 1'b0);
    selPos(); #2;
    chk("R5 clear beats preset", padOut, expPad(cfgBits, 1'b0, 1'b1));
    selNeg();
    arstIn = 1'b0; presetIn = 1'b0; sumIn = 1'b0;

    // R3: stop clock B (selected), clock A keeps running
    startCfg(4'b0101);
    applyVec(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clkB); enB = 1'b0; sumIn = 1'b0;
    repeat (4) @(posedge clkA);
    #1 chk("R3 clock A ignored when B selected", padOut, expPad(cfgBits, refQ, 1'b0));
    enB = 1'b1;

    // R3: stop clock A (selected), clock B keeps running
    startCfg(4'b0001);
    applyVec(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clkA); enA = 1'b0; sumIn = 1'b0;
    repeat (4) @(posedge clkB);
    #1 chk("R3 clock B ignored when A selected", padOut, expPad(cfgBits, refQ, 1'b0));
    enA = 1'b1;

    // R1/R2: combinational inverted path reacts without an edge
    startCfg(4'b0010);
    #3 sumIn = 1'b1;
    #1 chk("R1/R2 combinational inverted", padOut, 1'b0);

    // Random over every mode code
    for (int c = 0; c < 16; c++) begin
      startCfg(4'(c));
      for (int k = 0; k < 30; k++) begin
        applyVec(($urandom & 1) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                 ($urandom & 1) != 0, ($urandom % 4) != 0, ($urandom & 1) != 0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog (R1..R10 run): got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule